// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits between a host CPU and the memories of a tile-based video controller. The host writes 16-bit words to a control port, moves data through a data port and reads a status port. The decoder sorts control words into two kinds. A register-write word loads one of 24 eight-bit configuration registers. A pair of command words sets a 6-bit access code and a 16-bit address. Each data-port access then produces a one-cycle read or write strobe to video RAM, palette RAM or scroll RAM. The address advances by a programmable step after each access.

The display pipeline and the DMA engine read the configuration registers as one flat bus. The status port returns a fixed header, the flags supplied by the surrounding logic, and a sticky sprite-collision flag that is kept here. The write FIFO, the DMA engine and the video timing are outside this block. Their flags arrive as inputs. All outputs are registered. On a given clock edge at most one host strobe is acted on, in this order of priority: control write, data write, data read, status read.

Top module: `vctl_port_decoder`

## Requirements
- R1: A control word with bits 15:14 = 10, accepted while no command is half-assembled, loads bits 7:0 into the register numbered by bits 12:8. The new value shows on `cfg_regs` (register n at bits 8n+7:8n) one cycle later.
- R2: Register-write words that name register 24 or higher leave every register unchanged.
- R3: While bit 2 of register 1 is set (main mode), writes to registers 8 and 9 are dropped. While that bit is clear, registers 8 and 9 accept writes.
- R4: Any other control word that arrives with no command pending is a first command word. It copies bits 15:14 into code bits 1:0 and bits 13:0 into address bits 13:0, and it leaves code bits 5:2 and address bits 15:14 unchanged. The next control word is the second command word. It copies bits 7:4 into code bits 5:2 and bits 1:0 into address bits 15:14.
- R5: A first command word leaves a command pending. The next control word is taken as the second word even if its bits 15:14 are 10. A data-port access or a status read cancels the pending state.
- R6: Code 000001 with a data write pulses `vram_we`. 000000 with a data read pulses `vram_re`. 001100 with a data read pulses `vram_re` and `vram_byte`. 000011 with a write pulses `pal_we`. 001000 with a read pulses `pal_re`. 000101 with a write pulses `scrl_we`. 000100 with a read pulses `scrl_re`. Any other code, or an access in the other direction, pulses nothing.
- R7: When bit 4 of register 1 (DMA enable) is clear as the second command word arrives, code bit 5 is stored as 0.
- R8: Every data-port access, whether or not it strobes, adds register 15 to the address, modulo 2^16.
- R9: With a strobe, `mem_addr` carries the address in force before the access. For palette and scroll RAM this is the word index taken from address bits 6:1, zero-extended. For video RAM it is the full byte address. A write strobe carries the written word on `mem_wdata`.
- R10: A status read latches into `stat_word` the value 001101 in bits 15:10. Bits 9:0 hold, from high to low: FIFO empty, FIFO full, vertical interrupt pending, sprite overflow, sprite collision, odd frame, vblank, hblank, DMA busy, 50 Hz mode. The latched value holds until the next status read.
- R11: A `spr_col_evt` pulse sets a sticky collision flag. A status read returns the flag's value from before the read and then clears it, unless an event arrives in the same cycle.
- R12: After reset all registers, the code, the address and `stat_word` are zero, no command is pending and no strobe is active.
- R13: At most one memory strobe is high in any cycle. A strobe appears only in the cycle after a data-port access and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control-port write strobe |
| ctrl_wdata | input | 16 | Control-port write word |
| stat_rd | input | 1 | Status-port read strobe |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe |
| data_wdata | input | 16 | Data-port write word |
| fifo_empty | input | 1 | Write FIFO empty flag |
| fifo_full | input | 1 | Write FIFO full flag |
| vint_pend | input | 1 | Vertical interrupt pending |
| spr_ovf | input | 1 | Sprite overflow flag |
| spr_col_evt | input | 1 | Sprite collision event pulse |
| odd_frame | input | 1 | Odd interlaced frame |
| vblank | input | 1 | Vertical blanking |
| hblank | input | 1 | Horizontal blanking |
| dma_busy | input | 1 | DMA in progress |
| tv50_mode | input | 1 | 50 Hz display mode |
| stat_word | output | 16 | Latched status word |
| cfg_regs | output | 192 | Configuration registers, register n at bits 8n+7:8n |
| vram_we | output | 1 | Video RAM write strobe |
| vram_re | output | 1 | Video RAM read strobe |
| vram_byte | output | 1 | Byte-wide qualifier for a video RAM read |
| pal_we | output | 1 | Palette RAM write strobe |
| pal_re | output | 1 | Palette RAM read strobe |
| scrl_we | output | 1 | Scroll RAM write strobe |
| scrl_re | output | 1 | Scroll RAM read strobe |
| mem_addr | output | 16 | Byte address or word index for the strobed memory |
| mem_wdata | output | 16 | Write data for the strobed memory |

## Verification
Directed sequences come first. They use the literal code values, register numbers 8, 9, 24 and 31 in both mode settings, and a second command word that looks like a register write, so mistakes in code decoding and in the pending logic show up directly. A step of 0xFF from near the top of the address space checks the wrap-around. Back-to-back status reads after a collision pulse show the flag clearing. A long seeded random mix follows. It interleaves register writes (some of which change the step, the main mode and the DMA enable), command pairs with legal and illegal codes, accesses in both directions, and status reads with random flags. This mix exposes ordering faults that the fixed sequences do not reach.

// File: rtl/vctl_pkg.sv
`timescale 1ns/1ps
package vctl_pkg;
  localparam int CODE_W   = 6;
  localparam int WORD_W   = 16;
  localparam int REG_W    = 8;
  localparam int NUM_W    = 5;
  localparam int LO_W     = 14;
  localparam int MODE_REG = 1;
  localparam int MODE_BIT = 2;
  localparam int DMA_BIT  = 4;
  localparam int STEP_REG = 15;
  localparam int SKIP_A   = 8;
  localparam int SKIP_B   = 9;
  localparam logic [5:0] STAT_HDR = 6'b001101;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_VRAM_WR, TGT_VRAM_RD, TGT_VRAM_BRD,
    TGT_PAL_WR, TGT_PAL_RD, TGT_SCRL_WR, TGT_SCRL_RD
  } tgt_e;

  function automatic tgt_e decode_code(input logic [CODE_W-1:0] c);
    case (c)
      6'b000001: return TGT_VRAM_WR;
      6'b000000: return TGT_VRAM_RD;
      6'b001100: return TGT_VRAM_BRD;
      6'b000011: return TGT_PAL_WR;
      6'b001000: return TGT_PAL_RD;
      6'b000101: return TGT_SCRL_WR;
      6'b000100: return TGT_SCRL_RD;
      default:   return TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/vctl_regbank.sv
`timescale 1ns/1ps
module vctl_regbank
  import vctl_pkg::*;
#(
  parameter int NREG = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [NUM_W-1:0]      num,
  input  logic [REG_W-1:0]      val,
  output logic [NREG*REG_W-1:0] regs_flat
);
  logic [REG_W-1:0] r [NREG];
  logic main_mode;

  assign main_mode = r[MODE_REG][MODE_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit LOCKABLE = (i == SKIP_A) || (i == SKIP_B);
    always_ff @(posedge clk) begin
      if (rst) begin
        r[i] <= '0;
      end else if (we && num == NUM_W'(i) && !(LOCKABLE && main_mode)) begin
        r[i] <= val;
      end
    end
    assign regs_flat[i*REG_W +: REG_W] = r[i];
  end
endmodule

// File: rtl/vctl_cmd_track.sv
`timescale 1ns/1ps
module vctl_cmd_track
  import vctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [WORD_W-1:0] cw,
  input  logic              acc,
  input  logic              srd,
  input  logic              dma_en,
  input  logic [REG_W-1:0]  step,
  output logic [CODE_W-1:0] code,
  output logic [ADDR_W-1:0] addr,
  output logic              pending,
  output logic              reg_we,
  output logic [NUM_W-1:0]  reg_num,
  output logic [REG_W-1:0]  reg_val
);
  localparam int HI_W = ADDR_W - LO_W;

  assign reg_we  = ctrl_wr && !pending && (cw[15:14] == 2'b10);
  assign reg_num = cw[8 +: NUM_W];
  assign reg_val = cw[REG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      code    <= '0;
      addr    <= '0;
      pending <= 1'b0;
    end else if (ctrl_wr) begin
      if (pending) begin
        code[5]             <= cw[7] & dma_en;
        code[4:2]           <= cw[6:4];
        addr[ADDR_W-1:LO_W] <= cw[HI_W-1:0];
        pending             <= 1'b0;
      end else if (!reg_we) begin
        code[1:0]      <= cw[15:14];
        addr[LO_W-1:0] <= cw[LO_W-1:0];
        pending        <= 1'b1;
      end
    end else if (acc) begin
      addr    <= addr + ADDR_W'(step);
      pending <= 1'b0;
    end else if (srd) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/vctl_mem_port.sv
`timescale 1ns/1ps
module vctl_mem_port
  import vctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_wr,
  input  logic              do_rd,
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              vram_we,
  output logic              vram_re,
  output logic              vram_byte,
  output logic              pal_we,
  output logic              pal_re,
  output logic              scrl_we,
  output logic              scrl_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  tgt_e tgt;
  logic word_ram;

  assign tgt      = decode_code(code);
  assign word_ram = (tgt == TGT_PAL_WR) || (tgt == TGT_PAL_RD) ||
                    (tgt == TGT_SCRL_WR) || (tgt == TGT_SCRL_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      vram_we   <= 1'b0;
      vram_re   <= 1'b0;
      vram_byte <= 1'b0;
      pal_we    <= 1'b0;
      pal_re    <= 1'b0;
      scrl_we   <= 1'b0;
      scrl_re   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      vram_we   <= do_wr && (tgt == TGT_VRAM_WR);
      vram_re   <= do_rd && ((tgt == TGT_VRAM_RD) || (tgt == TGT_VRAM_BRD));
      vram_byte <= do_rd && (tgt == TGT_VRAM_BRD);
      pal_we    <= do_wr && (tgt == TGT_PAL_WR);
      pal_re    <= do_rd && (tgt == TGT_PAL_RD);
      scrl_we   <= do_wr && (tgt == TGT_SCRL_WR);
      scrl_re   <= do_rd && (tgt == TGT_SCRL_RD);
      if (do_wr || do_rd) begin
        mem_addr <= word_ram ? ADDR_W'(addr[IDX_W:1]) : addr;
      end
      if (do_wr) begin
        mem_wdata <= wdata;
      end
    end
  end
endmodule

// File: rtl/vctl_status.sv
`timescale 1ns/1ps
module vctl_status
  import vctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              srd,
  input  logic              col_evt,
  input  logic [3:0]        flags_hi,
  input  logic [4:0]        flags_lo,
  output logic              col_q,
  output logic [WORD_W-1:0] stat_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      col_q     <= 1'b0;
      stat_word <= '0;
    end else begin
      col_q <= col_evt | (col_q & ~srd);
      if (srd) begin
        stat_word <= {STAT_HDR, flags_hi, col_q, flags_lo};
      end
    end
  end
endmodule

// File: rtl/vctl_port_decoder.sv
`timescale 1ns/1ps
module vctl_port_decoder
  import vctl_pkg::*;
#(
  parameter int NREG   = 24,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ctrl_wr,
  input  logic [15:0]           ctrl_wdata,
  input  logic                  stat_rd,
  input  logic                  data_wr,
  input  logic                  data_rd,
  input  logic [15:0]           data_wdata,
  input  logic                  fifo_empty,
  input  logic                  fifo_full,
  input  logic                  vint_pend,
  input  logic                  spr_ovf,
  input  logic                  spr_col_evt,
  input  logic                  odd_frame,
  input  logic                  vblank,
  input  logic                  hblank,
  input  logic                  dma_busy,
  input  logic                  tv50_mode,
  output logic [15:0]           stat_word,
  output logic [NREG*REG_W-1:0] cfg_regs,
  output logic                  vram_we,
  output logic                  vram_re,
  output logic                  vram_byte,
  output logic                  pal_we,
  output logic                  pal_re,
  output logic                  scrl_we,
  output logic                  scrl_re,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [15:0]           mem_wdata
);
  logic              do_wr, do_rd, acc, srd;
  logic              reg_we;
  logic [NUM_W-1:0]  reg_num;
  logic [REG_W-1:0]  reg_val;
  logic [CODE_W-1:0] cmd_code;
  logic [ADDR_W-1:0] cmd_addr;
  logic              cmd_pending;
  logic [REG_W-1:0]  step_val;
  logic              dma_en;
  logic              col_sticky;

  assign do_wr    = !ctrl_wr && data_wr;
  assign do_rd    = !ctrl_wr && !data_wr && data_rd;
  assign acc      = do_wr || do_rd;
  assign srd      = stat_rd && !ctrl_wr && !data_wr && !data_rd;
  assign step_val = cfg_regs[STEP_REG*REG_W +: REG_W];
  assign dma_en   = cfg_regs[MODE_REG*REG_W + DMA_BIT];

  vctl_regbank #(.NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .num(reg_num), .val(reg_val),
    .regs_flat(cfg_regs)
  );

  vctl_cmd_track #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .cw(ctrl_wdata), .acc(acc),
    .srd(srd), .dma_en(dma_en), .step(step_val), .code(cmd_code),
    .addr(cmd_addr), .pending(cmd_pending), .reg_we(reg_we),
    .reg_num(reg_num), .reg_val(reg_val)
  );

  vctl_mem_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst(rst), .do_wr(do_wr), .do_rd(do_rd), .code(cmd_code),
    .addr(cmd_addr), .wdata(data_wdata), .vram_we(vram_we),
    .vram_re(vram_re), .vram_byte(vram_byte), .pal_we(pal_we),
    .pal_re(pal_re), .scrl_we(scrl_we), .scrl_re(scrl_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  vctl_status u_stat (
    .clk(clk), .rst(rst), .srd(srd), .col_evt(spr_col_evt),
    .flags_hi({fifo_empty, fifo_full, vint_pend, spr_ovf}),
    .flags_lo({odd_frame, vblank, hblank, dma_busy, tv50_mode}),
    .col_q(col_sticky), .stat_word(stat_word)
  );
endmodule

// File: rtl/vctl_port_checker.sv
`timescale 1ns/1ps
module vctl_port_checker (
  input logic        clk,
  input logic        rst,
  input logic        ctrl_wr,
  input logic [15:0] ctrl_wdata,
  input logic        data_wr,
  input logic        data_rd,
  input logic        stat_rd,
  input logic        spr_col_evt,
  input logic        pending,
  input logic [15:0] addr,
  input logic [7:0]  step,
  input logic [5:0]  code,
  input logic        dma_en,
  input logic        col_q,
  input logic [6:0]  strobes,
  input logic [15:0] mem_addr,
  input logic [15:0] stat_word
);
  logic acc_i, srd_i, small_i;
  assign acc_i   = !ctrl_wr && (data_wr || data_rd);
  assign srd_i   = stat_rd && !ctrl_wr && !data_wr && !data_rd;
  assign small_i = |strobes[3:0];

  a_r8_addr_step: assert property (@(posedge clk) disable iff (rst)
    acc_i |=> addr == 16'($past(addr) + 16'($past(step))));
  a_r5_pending_drop: assert property (@(posedge clk) disable iff (rst)
    (acc_i || srd_i) |=> !pending);
  a_r5_pending_set: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !pending && ctrl_wdata[15:14] != 2'b10) |=> pending);
  a_r7_cd5_masked: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && pending && !dma_en) |=> !code[5]);
  a_r13_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes[6], strobes[4:0]}));
  a_r13_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    (|strobes) |-> $past(data_wr || data_rd));
  a_r11_col_clear: assert property (@(posedge clk) disable iff (rst)
    (srd_i && !spr_col_evt) |=> !col_q);
  a_r10_header: assert property (@(posedge clk) disable iff (rst)
    srd_i |=> stat_word[15:10] == 6'b001101);
  a_r9_word_index: assert property (@(posedge clk) disable iff (rst)
    small_i |-> mem_addr[15:6] == 10'd0);
endmodule

bind vctl_port_decoder vctl_port_checker u_chk (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
  .data_wr(data_wr), .data_rd(data_rd), .stat_rd(stat_rd),
  .spr_col_evt(spr_col_evt), .pending(cmd_pending), .addr(cmd_addr),
  .step(step_val), .code(cmd_code), .dma_en(dma_en), .col_q(col_sticky),
  .strobes({vram_we, vram_re, vram_byte, pal_we, pal_re, scrl_we, scrl_re}),
  .mem_addr(mem_addr), .stat_word(stat_word)
);

// File: tb/tb_vctl_port_decoder.sv
`timescale 1ns/1ps
module tb_vctl_port_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_wr = 0, stat_rd = 0, data_wr = 0, data_rd = 0;
  logic [15:0] ctrl_wdata = 0, data_wdata = 0;
  logic fifo_empty = 0, fifo_full = 0, vint_pend = 0, spr_ovf = 0, spr_col_evt = 0;
  logic odd_frame = 0, vblank = 0, hblank = 0, dma_busy = 0, tv50_mode = 0;
  logic [15:0]  stat_word;
  logic [191:0] cfg_regs;
  logic vram_we, vram_re, vram_byte, pal_we, pal_re, scrl_we, scrl_re;
  logic [15:0] mem_addr, mem_wdata;

  always #2.5 clk = ~clk;

  vctl_port_decoder dut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .stat_rd(stat_rd), .data_wr(data_wr), .data_rd(data_rd),
    .data_wdata(data_wdata), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .vint_pend(vint_pend), .spr_ovf(spr_ovf), .spr_col_evt(spr_col_evt),
    .odd_frame(odd_frame), .vblank(vblank), .hblank(hblank),
    .dma_busy(dma_busy), .tv50_mode(tv50_mode), .stat_word(stat_word),
    .cfg_regs(cfg_regs), .vram_we(vram_we), .vram_re(vram_re),
    .vram_byte(vram_byte), .pal_we(pal_we), .pal_re(pal_re),
    .scrl_we(scrl_we), .scrl_re(scrl_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0]  m_regs [24];
  logic [5:0]  m_code = 0;
  logic [15:0] m_addr = 0;
  logic        m_pend = 0;
  logic        m_col = 0;
  logic [15:0] m_stat = 0;

  task automatic check(input string tag, input logic [191:0] got, input logic [191:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [191:0] flat_regs();
    logic [191:0] f;
    for (int i = 0; i < 24; i++) f[i*8 +: 8] = m_regs[i];
    return f;
  endfunction

  // order: vram_we vram_re vram_byte pal_we pal_re scrl_we scrl_re
  function automatic logic [6:0] exp_strobe(input logic [5:0] c, input logic wr);
    if (wr) begin
      if (c == 6'b000001) return 7'b1000000;
      if (c == 6'b000011) return 7'b0001000;
      if (c == 6'b000101) return 7'b0000010;
    end else begin
      if (c == 6'b000000) return 7'b0100000;
      if (c == 6'b001100) return 7'b0110000;
      if (c == 6'b001000) return 7'b0000100;
      if (c == 6'b000100) return 7'b0000001;
    end
    return 7'b0;
  endfunction

  task automatic op(input bit cw, input logic [15:0] cwd, input bit dw, input bit dr,
                    input logic [15:0] dwd, input bit sr, input bit cev, input string tag);
    logic [9:0]  st;
    logic [6:0]  es;
    logic [15:0] ema, ewd;
    logic [4:0]  n;
    st = 10'($urandom);
    @(negedge clk);
    ctrl_wr = cw; ctrl_wdata = cwd; data_wr = dw; data_rd = dr; data_wdata = dwd;
    stat_rd = sr; spr_col_evt = cev;
    {fifo_empty, fifo_full, vint_pend, spr_ovf} = st[9:6];
    {odd_frame, vblank, hblank, dma_busy, tv50_mode} = st[4:0];
    @(posedge clk);
    es = 0; ema = 0; ewd = 0;
    if (cw) begin
      if (m_pend) begin
        m_code[5] = cwd[7] & m_regs[1][4];
        m_code[4:2] = cwd[6:4];
        m_addr[15:14] = cwd[1:0];
        m_pend = 0;
      end else if (cwd[15:14] == 2'b10) begin
        n = cwd[12:8];
        if (n < 24 && !(m_regs[1][2] && (n == 8 || n == 9))) m_regs[n] = cwd[7:0];
      end else begin
        m_code[1:0] = cwd[15:14];
        m_addr[13:0] = cwd[13:0];
        m_pend = 1;
      end
    end else if (dw || dr) begin
      es = exp_strobe(m_code, dw);
      ema = (es[3:0] != 0) ? {10'd0, m_addr[6:1]} : m_addr;
      ewd = dwd;
      m_addr = m_addr + {8'd0, m_regs[15]};
      m_pend = 0;
    end else if (sr) begin
      m_stat = {6'b001101, st[9:6], m_col, st[4:0]};
      m_pend = 0;
    end
    m_col = cev | (m_col & !(sr && !cw && !dw && !dr));
    #1;
    check({tag, " strobes"}, 192'({vram_we, vram_re, vram_byte, pal_we, pal_re, scrl_we, scrl_re}), 192'(es));
    if (es != 0) check({tag, " mem_addr"}, 192'(mem_addr), 192'(ema));
    if (es[6] || es[3] || es[1]) check({tag, " mem_wdata"}, 192'(mem_wdata), 192'(ewd));
    check({tag, " stat_word"}, 192'(stat_word), 192'(m_stat));
    check({tag, " cfg_regs"}, cfg_regs, flat_regs());
  endtask

  task automatic ctl(input logic [15:0] w, input string tag);
    op(1, w, 0, 0, 16'h0, 0, 0, tag);
  endtask
  task automatic dwr(input logic [15:0] d, input string tag);
    op(0, 16'h0, 1, 0, d, 0, 0, tag);
  endtask
  task automatic drd(input string tag);
    op(0, 16'h0, 0, 1, 16'h0, 0, 0, tag);
  endtask
  task automatic srd(input bit cev, input string tag);
    op(0, 16'h0, 0, 0, 16'h0, 1, cev, tag);
  endtask

  initial begin
    int unsigned seed_tmp;
    logic [5:0] codes [8];
    seed_tmp = $urandom(32'h1d2c);
    codes = '{6'b000001, 6'b000000, 6'b001100, 6'b000011, 6'b001000,
              6'b000101, 6'b000100, 6'b101010};
    for (int i = 0; i < 24; i++) m_regs[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R12: reset state
    check("R12 cfg_regs", cfg_regs, 192'd0);
    check("R12 stat_word", 192'(stat_word), 192'd0);
    check("R12 strobes", 192'({vram_we, vram_re, vram_byte, pal_we, pal_re, scrl_we, scrl_re}), 192'd0);

    ctl(16'h8F02, "R1");
    ctl(16'h98AA, "R2");
    ctl(16'h9F55, "R2");
    ctl(16'h8104, "R3");
    ctl(16'h8855, "R3");
    ctl(16'h8966, "R3");
    ctl(16'h8100, "R3");
    ctl(16'h8855, "R3");
    ctl(16'h8114, "R1");
    ctl(16'h6C80, "R4");
    ctl(16'h0002, "R4");
    dwr(16'h1234, "R4");
    dwr(16'h5678, "R8");
    op(0, 16'h0, 0, 0, 16'h0, 0, 0, "R13");
    ctl(16'hC000, "R6");
    ctl(16'h0000, "R6");
    dwr(16'h0ABC, "R9");
    dwr(16'h0DEF, "R9");
    ctl(16'h4000, "R5");
    ctl(16'h8F10, "R5");
    dwr(16'h0101, "R5");
    ctl(16'h4000, "R5");
    srd(0, "R5");
    ctl(16'h8F04, "R5");
    ctl(16'h8104, "R7");
    ctl(16'h4000, "R7");
    ctl(16'h0080, "R7");
    dwr(16'h7777, "R7");
    ctl(16'h8114, "R7");
    ctl(16'h4000, "R7");
    ctl(16'h0080, "R7");
    dwr(16'h7777, "R7");
    ctl(16'h8FFF, "R8");
    ctl(16'h7FF0, "R8");
    ctl(16'h0003, "R8");
    dwr(16'hAAAA, "R8");
    dwr(16'hBBBB, "R8");
    ctl(16'h0046, "R9");
    ctl(16'h0020, "R9");
    drd("R9");
    ctl(16'h0010, "R6");
    ctl(16'h0030, "R6");
    drd("R6");
    dwr(16'h1111, "R6");
    op(0, 16'h0, 0, 0, 16'h0, 0, 1, "R11");
    srd(0, "R11");
    srd(0, "R11");
    srd(1, "R10");
    srd(0, "R10");

    for (int k = 0; k < 1500; k++) begin
      int unsigned r;
      logic [5:0]  c;
      logic [15:0] a;
      r = $urandom % 8;
      c = codes[$urandom % 8];
      a = 16'($urandom);
      case (r)
        0, 1: ctl({3'b100, 5'($urandom % 32), 8'($urandom)}, "R1/R2/R3");
        2, 3: begin
          ctl({c[1:0], a[13:0]}, "R4/R5");
          if ($urandom % 4 != 0) ctl({8'h00, c[5:2], 2'b00, a[15:14]}, "R4/R7");
        end
        4: dwr(16'($urandom), "R6/R8/R9");
        5: drd("R6/R8/R9");
        6: srd(1'($urandom), "R10/R11");
        default: op(0, 16'h0, 0, 0, 16'h0, 0, 1'($urandom), "R13");
      endcase
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #900000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule